// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block controls a single switchable power domain. It drives five controls: the domain clock enable, the isolation clamp, the retention save and restore strobes, the domain reset, and the power-switch enable. It also watches an acknowledge from the switch that reports when the supply has settled. A one-cycle request pulse starts a power-down or a power-up. The block steps through the controls in a fixed order and leaves a programmable gap of whole clock cycles between steps. After opening or closing the switch it waits until the acknowledge reaches the new level.

The two sequences use different orders. Power-down stops the clock, clamps the outputs, saves state, holds reset and then opens the switch. Power-up closes the switch, waits for the supply, releases reset, restores state, removes the clamp and then restarts the clock. The gap value is read from `gap_i` on the edge that accepts a request and is held for the rest of that sequence. If the acknowledge does not arrive in time, a timeout sets an error flag that stays set.

Top module: `pwr_dom_seq`

## Requirements
- R1: After the asynchronous hard reset the domain is on and every control is inactive: clk_en_o=1, iso_o=0, save_o=0, restore_o=0, dom_rst_o=0, sw_en_o=1, busy_o=0, done_o=0, err_o=0.
- R2: Let G be the gap latched when a request is accepted (a value of 0 counts as 1). A power-down starts on the edge where pd_req_i is sampled high while the domain is on and idle. On that edge clk_en_o falls. iso_o rises G edges later. save_o is high for exactly one cycle, starting 2G edges after the start. dom_rst_o rises 3G edges after the start, and sw_en_o falls 4G edges after the start.
- R3: After sw_en_o falls, sw_ack_i is sampled from the next edge onward. The power-down completes on the first edge that samples sw_ack_i low. From that edge busy_o is 0 and the domain stays off (clk_en_o=0, iso_o=1, dom_rst_o=1, sw_en_o=0).
- R4: A power-up starts on the edge where pu_req_i is sampled high while the domain is off and idle, and sw_en_o rises on that edge. From the next edge onward the block waits for sw_ack_i to be sampled high. On that edge dom_rst_o falls. restore_o is high for exactly one cycle, starting G edges later. iso_o falls 2G edges after the acknowledge, and clk_en_o rises 3G edges after it.
- R5: busy_o is 1 from the start edge up to the completion edge. A request sampled while busy_o is 1 is ignored, and this includes a request sampled on the completion edge.
- R6: A request that does not match the domain state is ignored (pd_req_i while off, pu_req_i while on). When both requests arrive together, only the one that matches the state takes effect.
- R7: done_o is high for exactly one cycle, starting on the completion edge of each sequence. It never occurs while busy_o is 1.
- R8: If TMO_CYCLES consecutive edges in a wait state sample no acknowledge, err_o rises. It then stays high until hard reset. The sequence keeps waiting and busy_o stays 1.
- R9: A change on gap_i during a sequence does not change that sequence's step timing.
- R10: Whenever clk_en_o is 1, iso_o and dom_rst_o are 0 and sw_en_o is 1. Whenever sw_en_o is 0, iso_o and dom_rst_o are 1. save_o is high only while isolation is on and reset is released. restore_o is high only while isolation is on, reset is released and the switch is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| gap_i | input | GAP_W | Cycles between sequence steps (0 acts as 1), latched at start |
| pd_req_i | input | 1 | Power-down request |
| pu_req_i | input | 1 | Power-up request |
| sw_ack_i | input | 1 | Switch acknowledge: 1 when supply present, 0 when removed |
| clk_en_o | output | 1 | Domain clock enable (1 = running) |
| iso_o | output | 1 | Isolation clamp enable |
| save_o | output | 1 | Retention save strobe |
| restore_o | output | 1 | Retention restore strobe |
| dom_rst_o | output | 1 | Domain reset, active high |
| sw_en_o | output | 1 | Power-switch enable (1 = closed, powered) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky acknowledge timeout flag |

## Verification
The risky coincidence is a request that is sampled on the same edge that completes a sequence. In that cycle the block is still busy, so the request must be dropped. It must not start a new sequence that would immediately reverse the domain. The bench provokes this by holding the opposite request high through a whole sequence and releasing it only in the cycle after done_o is seen. A reference model built on a time schedule then confirms that no second sequence started and that the outputs stay in the settled state. A second overlap is the last timeout edge coinciding with a sequence that keeps waiting. The bench checks there that err_o rises while busy_o stays high.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [2:0] {
    ST_ON,
    ST_PD_STEP,
    ST_PD_WAIT,
    ST_OFF,
    ST_PU_WAIT,
    ST_PU_STEP
  } seq_st_e;
endpackage

// File: rtl/pds_gap_timer.sv
module pds_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] load_val_i,
  output logic             tick_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/pds_ack_watch.sv
module pds_ack_watch #(
  parameter int TMO_CYCLES = 64,
  localparam int TW = $clog2(TMO_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic ok_i,
  output logic err_o
);
  localparam logic [TW-1:0] LAST = TW'(TMO_CYCLES - 1);
  logic [TW-1:0] wcnt_q;
  logic          err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      err_q  <= 1'b0;
    end else if (!wait_i) begin
      wcnt_q <= '0;
    end else if (!ok_i) begin
      if (wcnt_q == LAST) err_q  <= 1'b1;   // saturate, flag sticky
      else                wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
  parameter int GAP_W      = 4,
  parameter int TMO_CYCLES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             pd_req_i,
  input  logic             pu_req_i,
  input  logic             sw_ack_i,
  output logic             clk_en_o,
  output logic             iso_o,
  output logic             save_o,
  output logic             restore_o,
  output logic             dom_rst_o,
  output logic             sw_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  import pds_pkg::*;

  seq_st_e          st_q;
  logic [2:0]       sidx_q;
  logic [GAP_W-1:0] g_q;
  logic             clk_en_q, iso_q, save_q, restore_q, rst_q, sw_q, done_q;

  logic [GAP_W-1:0] gap_eff, load_val;
  logic             start_pd, start_pu, pu_acked, stepping, tick, fire, load;
  logic             in_wait, ack_ok;

  assign gap_eff  = (gap_i == '0) ? GAP_W'(1) : gap_i;
  assign start_pd = (st_q == ST_ON)  && pd_req_i;
  assign start_pu = (st_q == ST_OFF) && pu_req_i;
  assign pu_acked = (st_q == ST_PU_WAIT) && sw_ack_i;
  assign stepping = (st_q == ST_PD_STEP) || (st_q == ST_PU_STEP);
  assign fire     = stepping && tick;
  assign load     = start_pd || pu_acked || fire;
  assign load_val = start_pd ? gap_eff - 1'b1 : g_q - 1'b1;
  assign in_wait  = (st_q == ST_PD_WAIT) || (st_q == ST_PU_WAIT);
  assign ack_ok   = (st_q == ST_PD_WAIT) ? !sw_ack_i : sw_ack_i;

  pds_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_o     (tick)
  );

  pds_ack_watch #(.TMO_CYCLES(TMO_CYCLES)) u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wait_i (in_wait),
    .ok_i   (ack_ok),
    .err_o  (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_ON;
      sidx_q    <= '0;
      g_q       <= GAP_W'(1);
      clk_en_q  <= 1'b1;
      iso_q     <= 1'b0;
      save_q    <= 1'b0;
      restore_q <= 1'b0;
      rst_q     <= 1'b0;
      sw_q      <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      save_q    <= 1'b0;
      restore_q <= 1'b0;
      done_q    <= 1'b0;
      unique case (st_q)
        ST_ON: if (start_pd) begin
          clk_en_q <= 1'b0;
          g_q      <= gap_eff;
          sidx_q   <= 3'd1;
          st_q     <= ST_PD_STEP;
        end
        ST_PD_STEP: if (fire) begin
          sidx_q <= sidx_q + 3'd1;
          unique case (sidx_q)
            3'd1:    iso_q  <= 1'b1;
            3'd2:    save_q <= 1'b1;
            3'd3:    rst_q  <= 1'b1;
            default: begin
              sw_q <= 1'b0;
              st_q <= ST_PD_WAIT;
            end
          endcase
        end
        ST_PD_WAIT: if (!sw_ack_i) begin
          done_q <= 1'b1;
          st_q   <= ST_OFF;
        end
        ST_OFF: if (start_pu) begin
          sw_q <= 1'b1;
          g_q  <= gap_eff;
          st_q <= ST_PU_WAIT;
        end
        ST_PU_WAIT: if (pu_acked) begin
          rst_q  <= 1'b0;
          sidx_q <= 3'd1;
          st_q   <= ST_PU_STEP;
        end
        ST_PU_STEP: if (fire) begin
          sidx_q <= sidx_q + 3'd1;
          unique case (sidx_q)
            3'd1:    restore_q <= 1'b1;
            3'd2:    iso_q     <= 1'b0;
            default: begin
              clk_en_q <= 1'b1;
              done_q   <= 1'b1;
              st_q     <= ST_ON;
            end
          endcase
        end
        default: st_q <= ST_ON;
      endcase
    end
  end

  assign clk_en_o  = clk_en_q;
  assign iso_o     = iso_q;
  assign save_o    = save_q;
  assign restore_o = restore_q;
  assign dom_rst_o = rst_q;
  assign sw_en_o   = sw_q;
  assign done_o    = done_q;
  assign busy_o    = (st_q != ST_ON) && (st_q != ST_OFF);
endmodule

// File: rtl/pwr_dom_seq_chk.sv
module pwr_dom_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_en_o,
  input logic iso_o,
  input logic save_o,
  input logic restore_o,
  input logic dom_rst_o,
  input logic sw_en_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  assert_clk_on_safe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> (!iso_o && !dom_rst_o && sw_en_o));

  assert_sw_open_safe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_o |-> (iso_o && dom_rst_o && !clk_en_o));

  assert_save_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |-> (iso_o && !dom_rst_o && !clk_en_o && sw_en_o));

  assert_save_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |=> !save_o);

  assert_restore_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (iso_o && !dom_rst_o && sw_en_o && !clk_en_o));

  assert_restore_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> !restore_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind pwr_dom_seq pwr_dom_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_en_o  (clk_en_o),
  .iso_o     (iso_o),
  .save_o    (save_o),
  .restore_o (restore_o),
  .dom_rst_o (dom_rst_o),
  .sw_en_o   (sw_en_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/pwr_dom_seq_tb.sv
module pwr_dom_seq_tb;
  localparam int GAP_W = 4;
  localparam int TMO   = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [GAP_W-1:0] gap = 4'd3;
  logic             pd_req = 1'b0, pu_req = 1'b0, ack = 1'b1;
  logic             clk_en, iso, save, restore, drst, sw_en, busy, done, err;

  always #2.5 clk = ~clk;

  pwr_dom_seq #(.GAP_W(GAP_W), .TMO_CYCLES(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gap_i(gap), .pd_req_i(pd_req), .pu_req_i(pu_req),
    .sw_ack_i(ack), .clk_en_o(clk_en), .iso_o(iso), .save_o(save), .restore_o(restore),
    .dom_rst_o(drst), .sw_en_o(sw_en), .busy_o(busy), .done_o(done), .err_o(err)
  );

  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";
  bit en_cmp = 0;

  // switch model: ack follows sw_en after dly negedges, or freezes when dead
  logic [15:0] hist;
  int dly = 4;
  bit dead = 0;
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin hist <= '1; ack <= 1'b1; end
    else begin
      hist <= {hist[14:0], sw_en};
      if (!dead) ack <= (dly == 1) ? sw_en : hist[dly-2];
    end
  end

  // schedule-based reference model
  bit m_busy, m_dir, m_on, m_err, m_done;
  int m_t, m_tw, m_g, m_wc;
  task automatic miss();
    m_wc++;
    if (m_wc >= TMO) m_err = 1;
  endtask
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_on = 1; m_err = 0; m_done = 0; m_wc = 0; m_t = 0; m_tw = -1; m_g = 1; m_dir = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (m_on && pd_req) begin
          m_busy = 1; m_dir = 0; m_t = 0; m_wc = 0; m_g = (gap == 0) ? 1 : int'(gap);
        end else if (!m_on && pu_req) begin
          m_busy = 1; m_dir = 1; m_t = 0; m_tw = -1; m_wc = 0; m_g = (gap == 0) ? 1 : int'(gap);
        end
      end else begin
        m_t++;
        if (!m_dir) begin
          if (m_t > 4*m_g) begin
            if (!ack) begin m_busy = 0; m_on = 0; m_done = 1; end
            else miss();
          end
        end else if (m_tw < 0) begin
          if (ack) m_tw = m_t; else miss();
        end else if (m_t - m_tw == 3*m_g) begin
          m_busy = 0; m_on = 1; m_done = 1;
        end
      end
    end
  end

  function automatic logic [8:0] expect_vec();
    logic c, i, s, r, d, w;
    c = 0; i = 0; s = 0; r = 0; d = 0; w = 0;
    if (!m_busy) begin
      if (m_on) begin c = 1; w = 1; end
      else begin i = 1; d = 1; end
    end else if (!m_dir) begin
      i = (m_t >= m_g); s = (m_t == 2*m_g); d = (m_t >= 3*m_g); w = !(m_t >= 4*m_g);
    end else begin
      w = 1;
      if (m_tw < 0) begin i = 1; d = 1; end
      else begin r = (m_t - m_tw == m_g); i = (m_t - m_tw < 2*m_g); end
    end
    return {c, i, s, r, d, w, m_busy, m_done, m_err};
  endfunction

  task automatic chk(input int act, input int exp, input string rq, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (en_cmp && rst_n) begin
      chk({clk_en, iso, save, restore, drst, sw_en, busy, done, err}, expect_vec(), tag, "outputs");
      if (clk_en) chk({iso, drst, sw_en}, 3'b001, "R10", "clk on invariant");
    end
  end

  task automatic idle_wait();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input bit down, input bit up);
    pd_req = down; pu_req = up;
    @(negedge clk);
    pd_req = 0; pu_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({clk_en, iso, save, restore, drst, sw_en, busy, done, err}, 9'b100001000, "R1", "reset state");
    en_cmp = 1;

    tag = "R2"; gap = 3; dly = 4; pulse(1, 0); idle_wait();
    tag = "R3"; chk({sw_en, iso, drst}, 3'b011, "R3", "off after power-down");
    tag = "R4"; pulse(0, 1); idle_wait();
    tag = "R2"; gap = 0; dly = 1; pulse(1, 0); idle_wait();
    tag = "R4"; gap = 2; dly = 9; pulse(0, 1); idle_wait();

    // requests while busy
    tag = "R5"; gap = 2; dly = 3; pulse(1, 0);
    repeat (3) @(negedge clk);
    pulse(1, 1); pulse(0, 1); idle_wait();
    chk({busy, sw_en}, 2'b00, "R5", "busy request ignored");

    // request held through completion edge of a power-up
    tag = "R5"; gap = 1; dly = 2; pulse(0, 1);
    pd_req = 1;
    @(negedge clk);
    while (!done) @(negedge clk);
    pd_req = 0;
    repeat (3) @(negedge clk);
    chk({busy, clk_en, sw_en}, 3'b011, "R5", "completion-edge request ignored");

    // mismatched and simultaneous requests
    tag = "R6"; pulse(0, 1);
    chk(busy, 0, "R6", "power-up while on ignored");
    pulse(1, 1);
    chk(busy, 1, "R6", "simultaneous requests start power-down");
    idle_wait();
    pulse(1, 0);
    chk(busy, 0, "R6", "power-down while off ignored");

    // gap change mid sequence, count done pulses
    begin
      int dn = 0;
      tag = "R9"; gap = 2; dly = 5; pulse(0, 1);
      gap = 9;
      while (m_busy || done) begin if (done) dn++; @(negedge clk); end
      chk(dn, 1, "R7", "single done pulse");
    end
    idle_wait();

    // dead switch: ack never falls
    tag = "R8"; gap = 1; dead = 1; pulse(1, 0);
    repeat (4 + TMO + 6) @(negedge clk);
    chk({err, busy}, 2'b11, "R8", "timeout flag while waiting");
    en_cmp = 0; rst_n = 0; dead = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk({clk_en, iso, drst, sw_en, busy, err}, 6'b100100, "R1", "reset clears error");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule